// File: doc/BRIEF.md
# Real-Time Clock Register Front End

This block is the host-facing register side of a real-time clock and calendar. A small byte-wide port reaches four locations: a configuration register, the high and low bytes of a 16-bit value window, and an unlock key register. The value window shows two of the seven calendar fields at a time. A two-bit window pointer in the configuration register selects the pair, and the pointer steps down by one each time the high byte is accessed. Software can therefore walk through the whole calendar by setting the pointer once and then alternating low and high accesses.

The calendar fields are write-protected. A write-enable bit in the configuration register guards them, and only a fixed key sequence can set that bit. A simple internal BCD counter runs from a clock-cycle prescaler while the block is enabled. The same prescaler drives a half-second phase bit, a sync flag that warns that a rollover is close, and an optional square-wave output.

Top module: `rtcc_regfront`

## Requirements
- R1: The port decodes address 0 as configuration, 1 as the value-window high byte, 2 as the value-window low byte and 3 as the key register. The configuration byte reads as {enable[7], 0[6], write_enable[5], sync[4], halfsec[3], out_enable[2], pointer[1:0]}. After reset, the configuration byte, rdata and rtc_out are all 0.
- R2: Pointer 0 maps high to minutes and low to seconds. Pointer 1 maps high to weekday and low to hours. Pointer 2 maps high to month and low to day. Pointer 3 maps high to a reserved byte and low to year. The reserved byte reads 0 and ignores writes.
- R3: Each read or write of the high byte lowers the pointer by one, evaluated after the access. At 0 the pointer stays at 0. Writing the configuration register loads the pointer from bits 1:0.
- R4: While write_enable is 0, writes to either value byte leave every calendar field unchanged.
- R5: The enable bit takes the written value only when write_enable was already 1 before the configuration write.
- R6: write_enable becomes 1 only through this sequence: key writes of 8'h55 and then 8'hAA, with the next access being a configuration write that has bit 5 set. Any other access in between aborts the sequence. A plain configuration write can clear write_enable but cannot set it.
- R7: halfsec reads 0 in the first half of each second and 1 in the second half. An accepted write to the seconds byte restarts the second and clears it.
- R8: sync reads 1 during the last SYNC_WIN clock cycles before each one-second tick while the block is enabled, and 0 otherwise.
- R9: Every TICKS_PER_SEC cycles while enabled, the BCD calendar advances by one second. The carries run seconds 59, minutes 59, hours 23, then the day. Days per month are 28, 30 or 31; February is always 28. The day carry also steps the weekday 6 to 0 and rolls month 12 and year 99 over.
- R10: While enable is 0, the prescaler and calendar hold their values and rtc_out is 0.
- R11: With enable and out_enable both 1, rtc_out follows halfsec with a delay of one cycle.
- R12: rdata is loaded on the clock edge of a read and holds its value between reads. The key register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, ignored when bus_wr is high |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| rtc_out | output | 1 | Half-second-phase square wave output |

## Verification
The assertions assume that a high strobe is exactly one access: a write takes priority over a simultaneous read. They also assume that host writes to a calendar field do not land on the cycle of a one-second tick. The bench drives one strobe at a time, with an idle cycle between accesses. It writes the calendar only while the block is disabled, or right after a seconds write has restarted the prescaler, so no write meets a tick. Every value written to a field is valid BCD, so the cascade checks rely only on the carry rules.

// File: rtl/rtcc_pkg.sv
package rtcc_pkg;
  typedef enum logic [1:0] {
    ADR_CFG = 2'd0,
    ADR_VHI = 2'd1,
    ADR_VLO = 2'd2,
    ADR_KEY = 2'd3
  } rtcc_addr_e;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [7:0] wday;
    logic [7:0] day;
    logic [7:0] mon;
    logic [7:0] year;
  } rtcc_time_t;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
    return v + 8'h01;
  endfunction

  function automatic logic [7:0] month_last_day(input logic [7:0] mon);
    case (mon)
      8'h02:                      return 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtcc_keycfg.sv
module rtcc_keycfg
  import rtcc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       acc,
  input  logic       cfg_wr,
  input  logic       key_wr,
  input  logic [7:0] wdata,
  output logic       en,
  output logic       wren,
  output logic       oe
);
  typedef enum logic [1:0] {K_IDLE, K_GOT1, K_ARMED} key_st_e;
  key_st_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= K_IDLE;
    end else if (acc) begin
      if (key_wr && wdata == KEY_FIRST)
        st <= K_GOT1;
      else if (st == K_GOT1 && key_wr && wdata == KEY_SECOND)
        st <= K_ARMED;
      else
        st <= K_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en   <= 1'b0;
      wren <= 1'b0;
      oe   <= 1'b0;
    end else if (cfg_wr) begin
      wren <= (st == K_ARMED) ? wdata[5] : (wren & wdata[5]);
      if (wren) en <= wdata[7];
      oe <= wdata[2];
    end
  end

  assert_wren_key_R6: assert property (@(posedge clk) disable iff (rst)
    (!wren && st != K_ARMED) |=> !wren);
  assert_en_lock_R5: assert property (@(posedge clk) disable iff (rst)
    !wren |=> $stable(en));
endmodule

// File: rtl/rtcc_winptr.sv
module rtcc_winptr #(
  parameter int PTR_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [PTR_W-1:0] wptr,
  input  logic             hi_acc,
  output logic [PTR_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst)                          ptr <= '0;
    else if (cfg_wr)                  ptr <= wptr;
    else if (hi_acc && ptr != '0)     ptr <= ptr - 1'b1;
  end

  assert_ptr_dec_R3: assert property (@(posedge clk) disable iff (rst)
    (hi_acc && !cfg_wr && ptr != '0) |=> ptr == $past(ptr) - 1'b1);
  assert_ptr_sat_R3: assert property (@(posedge clk) disable iff (rst)
    (hi_acc && !cfg_wr && ptr == '0) |=> ptr == '0);
endmodule

// File: rtl/rtcc_timebase.sv
module rtcc_timebase #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int SYNC_WIN      = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic sec_wr,
  output logic tick,
  output logic halfsec,
  output logic sync
);
  localparam int PW = $clog2(TICKS_PER_SEC);
  localparam logic [PW-1:0] LAST    = PW'(TICKS_PER_SEC - 1);
  localparam logic [PW-1:0] HALF    = PW'(TICKS_PER_SEC / 2);
  localparam logic [PW-1:0] SYNC_AT = PW'(TICKS_PER_SEC - SYNC_WIN);

  logic [PW-1:0] presc;

  always_ff @(posedge clk) begin
    if (rst || sec_wr)  presc <= '0;
    else if (run)       presc <= (presc == LAST) ? '0 : presc + 1'b1;
  end

  assign tick    = run && !sec_wr && presc == LAST;
  assign halfsec = presc >= HALF;
  assign sync    = run && presc >= SYNC_AT;

  assert_halfsec_clr_R7: assert property (@(posedge clk) disable iff (rst)
    sec_wr |=> !halfsec);
  assert_tick_in_sync_R8: assert property (@(posedge clk) disable iff (rst)
    tick |-> sync);
endmodule

// File: rtl/rtcc_calendar.sv
module rtcc_calendar
  import rtcc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       wr_hi,
  input  logic       wr_lo,
  input  logic [1:0] ptr,
  input  logic [7:0] wdata,
  output rtcc_time_t cal
);
  rtcc_time_t nxt;

  always_comb begin
    nxt = cal;
    if (tick) begin
      nxt.sec = (cal.sec == 8'h59) ? 8'h00 : bcd_inc(cal.sec);
      if (cal.sec == 8'h59) begin
        nxt.min = (cal.min == 8'h59) ? 8'h00 : bcd_inc(cal.min);
        if (cal.min == 8'h59) begin
          nxt.hour = (cal.hour == 8'h23) ? 8'h00 : bcd_inc(cal.hour);
          if (cal.hour == 8'h23) begin
            nxt.wday = (cal.wday == 8'h06) ? 8'h00 : bcd_inc(cal.wday);
            nxt.day  = (cal.day == month_last_day(cal.mon)) ? 8'h01 : bcd_inc(cal.day);
            if (cal.day == month_last_day(cal.mon)) begin
              nxt.mon = (cal.mon == 8'h12) ? 8'h01 : bcd_inc(cal.mon);
              if (cal.mon == 8'h12)
                nxt.year = (cal.year == 8'h99) ? 8'h00 : bcd_inc(cal.year);
            end
          end
        end
      end
    end
    if (wr_lo) begin
      case (ptr)
        2'd0: nxt.sec  = wdata;
        2'd1: nxt.hour = wdata;
        2'd2: nxt.day  = wdata;
        2'd3: nxt.year = wdata;
      endcase
    end
    if (wr_hi) begin
      case (ptr)
        2'd0:    nxt.min  = wdata;
        2'd1:    nxt.wday = wdata;
        2'd2:    nxt.mon  = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cal <= '{sec: 8'h00, min: 8'h00, hour: 8'h00, wday: 8'h00,
                      day: 8'h01, mon: 8'h01, year: 8'h00};
    else     cal <= nxt;
  end
endmodule

// File: rtl/rtcc_regfront.sv
module rtcc_regfront
  import rtcc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int SYNC_WIN      = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       rtc_out
);
  rtcc_addr_e adr;
  logic acc, do_rd, cfg_wr, key_wr, hi_acc, val_wr, wr_hi, wr_lo, sec_wr;
  logic en, wren, oe, tick, halfsec, sync;
  logic [1:0] ptr;
  rtcc_time_t cal;
  logic [7:0] hi_sel, lo_sel;

  assign adr    = rtcc_addr_e'(bus_addr);
  assign acc    = bus_wr | bus_rd;
  assign do_rd  = bus_rd & ~bus_wr;
  assign cfg_wr = bus_wr && adr == ADR_CFG;
  assign key_wr = bus_wr && adr == ADR_KEY;
  assign hi_acc = acc && adr == ADR_VHI;
  assign val_wr = bus_wr && (adr == ADR_VHI || adr == ADR_VLO);
  assign wr_hi  = bus_wr && wren && adr == ADR_VHI;
  assign wr_lo  = bus_wr && wren && adr == ADR_VLO;
  assign sec_wr = wr_lo && ptr == 2'd0;

  rtcc_keycfg u_keycfg (
    .clk(clk), .rst(rst), .acc(acc), .cfg_wr(cfg_wr), .key_wr(key_wr),
    .wdata(bus_wdata), .en(en), .wren(wren), .oe(oe)
  );

  rtcc_winptr #(.PTR_W(2)) u_winptr (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .wptr(bus_wdata[1:0]),
    .hi_acc(hi_acc), .ptr(ptr)
  );

  rtcc_timebase #(.TICKS_PER_SEC(TICKS_PER_SEC), .SYNC_WIN(SYNC_WIN)) u_timebase (
    .clk(clk), .rst(rst), .run(en), .sec_wr(sec_wr),
    .tick(tick), .halfsec(halfsec), .sync(sync)
  );

  rtcc_calendar u_calendar (
    .clk(clk), .rst(rst), .tick(tick), .wr_hi(wr_hi), .wr_lo(wr_lo),
    .ptr(ptr), .wdata(bus_wdata), .cal(cal)
  );

  always_comb begin
    case (ptr)
      2'd0: begin hi_sel = cal.min;  lo_sel = cal.sec;  end
      2'd1: begin hi_sel = cal.wday; lo_sel = cal.hour; end
      2'd2: begin hi_sel = cal.mon;  lo_sel = cal.day;  end
      default: begin hi_sel = 8'h00; lo_sel = cal.year; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= 8'h00;
      rtc_out   <= 1'b0;
    end else begin
      rtc_out <= en & oe & halfsec;
      if (do_rd) begin
        case (adr)
          ADR_CFG: bus_rdata <= {en, 1'b0, wren, sync, halfsec, oe, ptr};
          ADR_VHI: bus_rdata <= hi_sel;
          ADR_VLO: bus_rdata <= lo_sel;
          default: bus_rdata <= 8'h00;
        endcase
      end
    end
  end

  assert_locked_R4: assert property (@(posedge clk) disable iff (rst)
    (val_wr && !wren && !tick) |=> $stable(cal));
  assert_out_off_R10: assert property (@(posedge clk) disable iff (rst)
    !en |=> !rtc_out);
  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!en && !wr_hi && !wr_lo) |=> $stable(cal));
  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !do_rd |=> $stable(bus_rdata));
endmodule

// File: tb/rtcc_regfront_tb.sv
module rtcc_regfront_tb_top;
  localparam int TPS  = 100;
  localparam int SWIN = 32;
  localparam logic [1:0] A_CFG = 2'd0, A_VHI = 2'd1, A_VLO = 2'd2, A_KEY = 2'd3;
  // low byte = window low field, high byte = window high field; entry i at pointer 3-i
  localparam logic [15:0] VEC_TAB [0:3] = '{16'h0024, 16'h0715, 16'h0313, 16'h4530};

  logic clk = 1'b0, rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic rtc_out;
  int n_chk = 0, n_bad = 0;
  logic [7:0] rv, keep;

  always #10 clk = ~clk;

  rtcc_regfront #(.TICKS_PER_SEC(TPS), .SYNC_WIN(SWIN)) dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rtc_out(rtc_out)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic unlock(input logic [7:0] cfg);
    wr(A_KEY, 8'h55); wr(A_KEY, 8'hAA); wr(A_CFG, cfg);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 rdata reset", bus_rdata, 8'h00);
    check("R1 rtc_out reset", {7'd0, rtc_out}, 8'h00);
    rd(A_CFG, rv); check("R1 cfg reset", rv, 8'h00);

    unlock(8'h23);
    rd(A_CFG, rv); check("R6 unlocked, ptr=3", rv, 8'h23);

    // R2 table walk: write through decrementing pointer
    for (int i = 0; i < 4; i++) begin
      wr(A_VLO, VEC_TAB[i][7:0]);
      wr(A_VHI, VEC_TAB[i][15:8]);
    end
    rd(A_CFG, rv); check("R3 pointer at 0 after four high writes", rv, 8'h20);
    wr(A_CFG, 8'h23);
    for (int i = 0; i < 4; i++) begin
      rd(A_VLO, rv); check("R2 low field", rv, VEC_TAB[i][7:0]);
      rd(A_VHI, rv); check("R2 high field", rv, VEC_TAB[i][15:8]);
    end

    // R3 saturation at 0
    rd(A_VHI, rv); check("R3 saturated read min", rv, 8'h45);
    rd(A_CFG, rv); check("R3 pointer stays 0", rv, 8'h20);

    // R12 key reads 0 and rdata holds
    rd(A_KEY, rv); check("R12 key reads 0", rv, 8'h00);
    repeat (4) @(negedge clk);
    check("R12 rdata holds", bus_rdata, 8'h00);

    // R4 locked writes ignored
    wr(A_CFG, 8'h00);
    wr(A_VLO, 8'h11); wr(A_VHI, 8'h22);
    rd(A_VLO, rv); check("R4 sec unchanged", rv, 8'h30);
    rd(A_VHI, rv); check("R4 min unchanged", rv, 8'h45);

    // R6 plain write cannot set, aborted sequence fails
    wr(A_CFG, 8'h20);
    rd(A_CFG, rv); check("R6 plain write", rv, 8'h00);
    wr(A_KEY, 8'h55); rd(A_CFG, rv); wr(A_KEY, 8'hAA); wr(A_CFG, 8'h20);
    rd(A_CFG, rv); check("R6 aborted sequence", rv, 8'h00);

    // R5 enable locked
    wr(A_CFG, 8'h84);
    rd(A_CFG, rv); check("R5 enable locked", rv, 8'h04);
    unlock(8'hA0);
    rd(A_CFG, rv); check("R5 enable unchanged in unlocking write", rv, 8'h20);

    // R9 cascade: 99-12-31 wd6 23:59:58
    wr(A_CFG, 8'h23);
    wr(A_VLO, 8'h99); wr(A_VHI, 8'h77);
    wr(A_VLO, 8'h31); wr(A_VHI, 8'h12);
    wr(A_VLO, 8'h23); wr(A_VHI, 8'h06);
    wr(A_VLO, 8'h58); wr(A_VHI, 8'h59);
    wr(A_CFG, 8'hA4);
    repeat (250) @(negedge clk);
    wr(A_CFG, 8'hA7);
    rd(A_VLO, rv); check("R9 year rolls", rv, 8'h00);
    rd(A_VHI, rv); check("R2 reserved reads 0", rv, 8'h00);
    rd(A_VLO, rv); check("R9 day rolls", rv, 8'h01);
    rd(A_VHI, rv); check("R9 month rolls", rv, 8'h01);
    rd(A_VLO, rv); check("R9 hour rolls", rv, 8'h00);
    rd(A_VHI, rv); check("R9 weekday rolls", rv, 8'h00);
    rd(A_VLO, rv); check("R9 seconds", rv, 8'h00);
    rd(A_VHI, rv); check("R9 minutes", rv, 8'h00);

    // R7 / R8 / R11 halfsec, sync, output
    wr(A_CFG, 8'hA4);
    wr(A_VLO, 8'h10);
    rd(A_CFG, rv); check("R7 halfsec cleared by seconds write", rv, 8'hA4);
    check("R11 out low first half", {7'd0, rtc_out}, 8'h00);
    repeat (60) @(negedge clk);
    rd(A_CFG, rv); check("R7 second half, R8 no sync yet", rv, 8'hAC);
    check("R11 out high second half", {7'd0, rtc_out}, 8'h01);
    repeat (8) @(negedge clk);
    rd(A_CFG, rv); check("R8 sync near tick", rv, 8'hBC);

    // R10 disabled holds
    wr(A_CFG, 8'h24);
    @(negedge clk);
    check("R10 out low when disabled", {7'd0, rtc_out}, 8'h00);
    rd(A_VLO, keep);
    repeat (150) @(negedge clk);
    rd(A_VLO, rv); check("R10 seconds hold", rv, keep);
    rd(A_CFG, rv); check("R8 no sync while disabled", rv & 8'h10, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule